// File: doc/BRIEF.md
# Buffered SPI Master

This block is the master side of an SPI link. It works in any of the four clock modes and moves one 8-bit word per transfer. Every transfer is full duplex: one byte goes out on MOSI while another comes in on MISO. A one-word transmit buffer sits in front of the shift register. When the shifter is idle and the buffer holds a byte, that byte moves into the shifter and a transfer starts. When a transfer ends, the received byte is copied into a one-word receive buffer.

The pace of the serial clock comes from `bit_en`, a single-cycle enable. Each enable pulse moves SCLK by one half period. The block does not drive slave select; software or a general-purpose pin handles it. Software reaches the block through a small register bus with three locations:

- A write-only transmit buffer.
- A read-only receive buffer.
- A control/status location. A write to it sets the configuration. A read from it returns the flags.

The block has one level interrupt output. A configuration bit selects whether it reports "transmit buffer empty" or "transfer complete".

Top module: `spim_buffered`

## Requirements
- R1: Each transfer is 8 bits. The byte written to the transmit buffer appears on MOSI, and the byte the slave drives on MISO is then readable from the receive buffer at address 1.
- R2: Configuration bit 0 (polarity) sets the idle SCLK level. Bit 1 (phase) selects the sampling edge. With phase 0, MISO is sampled on the first edge of each bit. With phase 1, it is sampled on the second edge. SCLK moves only on cycles with `bit_en` high.
- R3: Configuration bit 2 selects bit order. 0 sends and receives the most significant bit first. 1 sends and receives the least significant bit first.
- R4: MISO is captured into a staging bit on the sampling edge and enters the shift register on the following edge. A change on MISO after a sampling edge does not alter the received byte.
- R5: A read of address 0 (transmit buffer) returns 0. A write to address 1 (receive buffer) leaves its contents unchanged.
- R6: When the shifter is idle and the transmit buffer is full, the buffer moves into the shifter. The tx-empty flag (status bit 0) sets at that move. A byte written during a transfer is sent right after it.
- R7: At the end of a transfer, the received byte goes to the receive buffer and the rx-full flag (status bit 1) and done flag (status bit 3) set. Reading the receive buffer clears rx-full.
- R8: If a transfer ends while rx-full is still set, the overrun flag (status bit 2) sets. Reading the status location clears it.
- R9: The done flag clears only on a read of the status location (address 2). Other reads and writes leave it set.
- R10: With configuration bit 3 at 0 (the reset value), `irq` follows tx-empty. With bit 3 at 1, `irq` follows the done flag.
- R11: SCLK rests at the polarity level whenever no transfer is active, and gives exactly 8 pulses (16 edges) per transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Half-period advance enable for SCLK |
| bus_addr | input | 2 | Register address: 0 tx buffer, 1 rx buffer, 2 control/status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; clears flags in the clock cycle it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt, level |

## Verification
The assertions rely on three things about the inputs. The configuration is rewritten only while no transfer is active. SCLK can move only on an enable pulse or on a configuration write. The transmit buffer is never written in the very cycle it moves into the shifter. The stimulus follows all three: it writes the configuration and then waits before arming the slave model, and it writes the transmit buffer either on an idle shifter or partway through a transfer. The slave model inverts MISO just after each sampling edge, so a design that samples on the wrong edge receives corrupted bytes.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam logic [1:0] ADR_TX = 2'd0;
    localparam logic [1:0] ADR_RX = 2'd1;
    localparam logic [1:0] ADR_CS = 2'd2;

    localparam int unsigned ST_TXE  = 0;
    localparam int unsigned ST_RXF  = 1;
    localparam int unsigned ST_OVR  = 2;
    localparam int unsigned ST_DONE = 3;

    typedef struct packed {
        logic irq_on_done;
        logic lsb_first;
        logic cpha;
        logic cpol;
    } spim_cfg_t;
endpackage

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  spim_cfg_t     cfg,
    input  logic          start,
    input  logic [DW-1:0] tx_byte,
    input  logic          miso,
    output logic          busy,
    output logic          done_pulse,
    output logic [DW-1:0] rx_byte,
    output logic          sclk,
    output logic          mosi
);
    localparam int unsigned EDGES = 2 * DW;
    localparam int unsigned CW    = $clog2(EDGES + 2);
    localparam logic [CW-1:0] LAST0 = CW'(EDGES);
    localparam logic [CW-1:0] LAST1 = CW'(EDGES + 1);
    localparam logic [CW-1:0] FIRST_SHIFT1 = CW'(3);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [DW-1:0] txsh;
        logic [DW-1:0] rxsh;
        logic          stage;
    } eng_t;

    function automatic logic [DW-1:0] flip(input logic [DW-1:0] v);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
        return r;
    endfunction

    eng_t          q, d;
    logic [CW-1:0] k;
    logic          smp, shf, last;

    always_comb begin
        d          = q;
        done_pulse = 1'b0;
        k          = q.cnt + 1'b1;
        smp        = 1'b0;
        shf        = 1'b0;
        last       = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.cnt   = '0;
                d.txsh  = cfg.lsb_first ? flip(tx_byte) : tx_byte;
                d.stage = 1'b0;
            end
        end else if (bit_en) begin
            d.cnt = k;
            if (cfg.cpha) begin
                smp  = !k[0] && (k <= LAST0);
                shf  = k[0] && (k >= FIRST_SHIFT1);
                last = (k == LAST1);
            end else begin
                smp  = k[0];
                shf  = !k[0];
                last = (k == LAST0);
            end
            if (shf) begin
                d.rxsh = {q.rxsh[DW-2:0], q.stage};
                d.txsh = {q.txsh[DW-2:0], 1'b0};
            end
            if (smp) d.stage = miso;
            if (last) begin
                d.busy     = 1'b0;
                done_pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_byte = cfg.lsb_first ? flip(d.rxsh) : d.rxsh;
    assign busy    = q.busy;
    assign sclk    = cfg.cpol ^ (q.busy & q.cnt[0]);
    assign mosi    = q.txsh[DW-1];
endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    input  logic          busy,
    input  logic          done_pulse,
    input  logic [DW-1:0] rx_byte,
    output spim_cfg_t     cfg,
    output logic          start,
    output logic [DW-1:0] tx_byte,
    output logic [DW-1:0] rx_buf,
    output logic [DW-1:0] status,
    output logic          irq
);
    typedef struct packed {
        spim_cfg_t     cfg;
        logic [DW-1:0] tx_buf;
        logic          tx_valid;
        logic [DW-1:0] rx_buf;
        logic          rx_full;
        logic          ovr;
        logic          done;
    } reg_t;

    reg_t q, d;
    logic wr_tx, wr_cs, rd_rx, rd_cs;

    always_comb begin
        d     = q;
        wr_tx = bus_wr && (bus_addr == ADR_TX);
        wr_cs = bus_wr && (bus_addr == ADR_CS);
        rd_rx = bus_rd && (bus_addr == ADR_RX);
        rd_cs = bus_rd && (bus_addr == ADR_CS);
        start = q.tx_valid && !busy;

        if (start) d.tx_valid = 1'b0;
        if (wr_tx) begin
            d.tx_buf   = bus_wdata;
            d.tx_valid = 1'b1;
        end
        if (wr_cs) d.cfg = spim_cfg_t'(bus_wdata[3:0]);
        if (rd_rx) d.rx_full = 1'b0;
        if (rd_cs) begin
            d.done = 1'b0;
            d.ovr  = 1'b0;
        end
        if (done_pulse) begin
            d.rx_buf  = rx_byte;
            d.rx_full = 1'b1;
            d.done    = 1'b1;
            if (q.rx_full && !rd_rx) d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        status          = '0;
        status[ST_TXE]  = !q.tx_valid;
        status[ST_RXF]  = q.rx_full;
        status[ST_OVR]  = q.ovr;
        status[ST_DONE] = q.done;
    end

    assign cfg     = q.cfg;
    assign tx_byte = q.tx_buf;
    assign rx_buf  = q.rx_buf;
    assign irq     = q.cfg.irq_on_done ? q.done : !q.tx_valid;
endmodule

// File: rtl/spim_buffered.sv
module spim_buffered
    import spim_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          irq
);
    spim_cfg_t     cfg;
    logic          start, busy, done_pulse;
    logic [DW-1:0] tx_byte, rx_byte, rx_buf, status;

    spim_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .done_pulse(done_pulse),
        .rx_byte   (rx_byte),
        .cfg       (cfg),
        .start     (start),
        .tx_byte   (tx_byte),
        .rx_buf    (rx_buf),
        .status    (status),
        .irq       (irq)
    );

    spim_engine #(.DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .cfg       (cfg),
        .start     (start),
        .tx_byte   (tx_byte),
        .miso      (miso),
        .busy      (busy),
        .done_pulse(done_pulse),
        .rx_byte   (rx_byte),
        .sclk      (sclk),
        .mosi      (mosi)
    );

    always_comb begin
        case (bus_addr)
            ADR_RX:  bus_rdata = rx_buf;
            ADR_CS:  bus_rdata = status;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_buffered_chk.sv
module spim_buffered_chk
    import spim_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_en,
    input logic [1:0]    bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic          busy,
    input logic          sclk,
    input spim_cfg_t     cfg,
    input logic [DW-1:0] status
);
    // R11: idle clock rests at the polarity level
    a_r11_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cfg.cpol));

    // R2: SCLK moves only on enable pulses or configuration writes
    a_r2_sclk_paced: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !(bus_wr && bus_addr == ADR_CS)) |=> $stable(sclk));

    // R6: the move into the shifter empties the tx buffer
    a_r6_move_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(bus_wr && bus_addr == ADR_TX)) |-> status[ST_TXE]);

    // R7: done never rises without rx-full
    a_r7_full_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_DONE]) |-> status[ST_RXF]);

    // R8: overrun only rises when the buffer was already full
    a_r8_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_OVR]) |-> $past(status[ST_RXF]));

    // R9: done is sticky until a status read
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_DONE] && !(bus_rd && bus_addr == ADR_CS)) |=> status[ST_DONE]);
endmodule

bind spim_buffered spim_buffered_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .bus_addr(bus_addr),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .busy    (busy),
    .sclk    (sclk),
    .cfg     (cfg),
    .status  (status)
);

// File: tb/spim_buffered_test.sv
module spim_buffered_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sclk, mosi, irq;
    logic       miso = 1'b1;

    int checks = 0;
    int errors = 0;

    // slave model state
    logic       armed = 1'b0;
    logic       cpol_b = 1'b0, cpha_b = 1'b0, lsb_b = 1'b0;
    logic       ps = 1'b0;
    int         ecnt = 0, nedge = 0, tix = 0, div = 1, dcnt = 0;
    logic [7:0] s_q [2];
    logic [7:0] m_got [2];

    spim_buffered uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic logic sbit(input logic [7:0] v, input int j, input logic lsb);
        return lsb ? v[j] : v[7-j];
    endfunction

    always @(negedge clk) begin
        if (dcnt >= div - 1) begin bit_en <= 1'b1; dcnt <= 0; end
        else begin bit_en <= 1'b0; dcnt <= dcnt + 1; end
    end

    // slave: samples on the same edge as the master, glitches MISO right after
    always @(negedge clk) begin
        if (armed && sclk !== ps) begin
            int j;
            ecnt  = ecnt + 1;
            nedge = nedge + 1;
            j = (ecnt - 1) / 2;
            if (cpha_b ? (ecnt % 2 == 0) : (ecnt % 2 == 1)) begin
                if (tix < 2) begin
                    m_got[tix][lsb_b ? j : 7 - j] = mosi;
                    miso = ~sbit(s_q[tix], j, lsb_b);
                end
                if (cpha_b && ecnt == 16) begin ecnt = 0; tix = tix + 1; end
            end else if (!cpha_b) begin
                if (ecnt == 16) begin
                    ecnt = 0;
                    tix  = tix + 1;
                    miso = (tix < 2) ? sbit(s_q[tix], 0, lsb_b) : 1'b1;
                end else if (tix < 2) miso = sbit(s_q[tix], ecnt / 2, lsb_b);
            end else if (tix < 2) begin
                miso = sbit(s_q[tix], j, lsb_b);
            end
        end
        ps = sclk;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic arm(input logic [7:0] cfg, input int dv, input logic [7:0] s0, input logic [7:0] s1);
        armed = 1'b0;
        div = dv;
        wr(2'd2, cfg);
        repeat (2) @(posedge clk);
        #1;
        cpol_b = cfg[0]; cpha_b = cfg[1]; lsb_b = cfg[2];
        s_q[0] = s0; s_q[1] = s1; m_got[0] = 8'h00; m_got[1] = 8'h00;
        tix = 0; ecnt = 0; nedge = 0; ps = sclk;
        miso = cpha_b ? 1'b1 : sbit(s0, 0, lsb_b);
        armed = 1'b1;
    endtask

    task automatic run(input logic [7:0] cfg, input int dv, input logic [7:0] tx, input logic [7:0] sx);
        logic [7:0] v;
        arm(cfg, dv, sx, 8'h00);
        chk(sclk == cfg[0], "R2 idle level", sclk, cfg[0]);
        wr(2'd0, tx);
        repeat (20 * dv + 10) @(posedge clk);
        #1;
        chk(nedge == 16, "R11 edge count", nedge, 16);
        chk(sclk == cfg[0], "R11 rest level", sclk, cfg[0]);
        chk(m_got[0] == tx, "R1 R3 mosi byte", m_got[0], tx);
        rd(2'd2, v);
        chk(v == 8'h0B, "R7 status after transfer", v, 8'h0B);
        rd(2'd1, v);
        chk(v == sx, "R1 R4 rx byte", v, sx);
        rd(2'd2, v);
        chk(v == 8'h01, "R9 R7 flags cleared", v, 8'h01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, tx, sx;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b0, "R11 reset sclk", sclk, 0);
        chk(irq == 1'b1, "R10 reset irq follows tx-empty", irq, 1);
        rd(2'd2, v);
        chk(v == 8'h01, "R6 reset status", v, 8'h01);

        // sweep: modes, bit order, two enable rates
        for (int m = 0; m < 4; m++)
            for (int l = 0; l < 2; l++)
                for (int dv = 1; dv <= 2; dv++) begin
                    tx = 8'(m * 53 + l * 29 + dv * 7 + 8'h3C);
                    sx = 8'(tx * 3 + 8'h91);
                    run(8'({l[0], m[1:0]}), dv, tx, sx);
                end

        // R5 access rules
        run(8'h00, 1, 8'hC3, 8'h5A);
        wr(2'd1, 8'h77);
        rd(2'd1, v);
        chk(v == 8'h5A, "R5 rx not writable", v, 8'h5A);
        rd(2'd0, v);
        chk(v == 8'h00, "R5 tx not readable", v, 8'h00);

        // R6 and R8: back-to-back bytes, rx left unread
        arm(8'h00, 2, 8'h1E, 8'hE7);
        wr(2'd0, 8'h96);
        repeat (3) @(posedge clk);
        rd(2'd2, v);
        chk(v[0] == 1'b1, "R6 empty after move", v[0], 1);
        wr(2'd0, 8'h4B);
        rd(2'd2, v);
        chk(v[0] == 1'b0, "R6 full while queued", v[0], 0);
        repeat (120) @(posedge clk);
        chk(m_got[0] == 8'h96, "R6 first byte", m_got[0], 8'h96);
        chk(m_got[1] == 8'h4B, "R6 queued byte follows", m_got[1], 8'h4B);
        rd(2'd2, v);
        chk(v == 8'h0F, "R8 overrun flagged", v, 8'h0F);
        rd(2'd1, v);
        chk(v == 8'hE7, "R8 newest byte kept", v, 8'hE7);
        rd(2'd2, v);
        chk(v == 8'h01, "R8 overrun cleared by status read", v, 8'h01);

        // R10 / R9: interrupt on completion
        chk(irq == 1'b1, "R10 tx-empty source", irq, 1);
        arm(8'h08, 1, 8'h33, 8'h00);
        #1;
        chk(irq == 1'b0, "R10 done source idle", irq, 0);
        wr(2'd0, 8'hA9);
        repeat (30) @(posedge clk);
        #1;
        chk(irq == 1'b1, "R10 irq on completion", irq, 1);
        rd(2'd1, v);
        chk(v == 8'h33, "R1 rx byte", v, 8'h33);
        #1;
        chk(irq == 1'b1, "R9 rx read keeps done", irq, 1);
        rd(2'd2, v);
        chk(v == 8'h09, "R9 status before clear", v, 8'h09);
        #1;
        chk(irq == 1'b0, "R10 irq drops after status read", irq, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule